// File: doc/BRIEF.md
# Sticky Fault and Load-Diagnostic Register Bank

This block is a byte-wide register file behind a simple synchronous read/write port, such as the one a serial-bus slave presents to its register space. It has four kinds of register. Sticky fault registers capture level-type fault signals from monitor logic. Sticky load-diagnostic registers collect the result bits of diagnostic runs. Live status registers pass the present state of their inputs straight through. Control registers drive the rest of the device.

A fault bit stays set after its fault goes away. It is cleared only by a read of its register made while the fault is already gone, so software always sees each fault event at least once. Diagnostic results build up over failed runs, and only a passing run clears them. Some control fields are locked and accept new values only while the device reports hi-Z mode.

Top module: `fault_diag_regbank`

## Requirements
- R1: After reset, every fault and diagnostic bit is 0 and `regRdData` is 0x00. The control registers take their parameter defaults: 0x0F at address 0x08, 0x20 at 0x0A, and 0x00 at all others.
- R2: Fault input bit `faultIn[8k+j]` sets bit j of fault register k. The fault registers are k=0 at address 0x00, k=1 at 0x01 and k=2 at 0x13. The bit is set from the clock edge that samples the input high, and it stays set after the input falls.
- R3: A read of a fault register clears, at that read's clock edge, each bit whose fault input is low in the read cycle. Bits whose input is still high stay set.
- R4: A fault input that rises in the same cycle as a clearing read of its register leaves its bit set.
- R5: When `regRdEn` is high, `regRdData` takes the register value as it was before that clock edge, and it shows that value from the edge onward. Without a read, `regRdData` holds its value.
- R6: When `diagDone` is high with `diagPass` low, `diagResult` is ORed into the two diagnostic registers: bits 7:0 go to address 0x02 and bits 15:8 go to 0x03. When `diagDone` is high with `diagPass` high, both registers clear. Reads never clear them.
- R7: A read of addresses 0x04 to 0x07 returns `statusIn` byte (address-0x04) as sampled in the read cycle.
- R8: The control registers sit at addresses 0x08 to 0x0D (bytes 0 to 5 of `ctrlOut`) and at 0x10 (byte 6), and they read back their value. A write updates unlocked bits at any time. Bits in the lock mask (all of 0x09, and bit 7 of 0x0B) change only while `hizMode` is 1.
- R9: Reads of unmapped addresses return 0x00. Writes to fault, diagnostic, status or unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regRdEn | input | 1 | Read strobe, one cycle |
| regWrEn | input | 1 | Write strobe, one cycle |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Registered read data |
| faultIn | input | 24 | Level fault inputs, 8 per fault register |
| diagDone | input | 1 | Diagnostic run completion strobe |
| diagPass | input | 1 | Diagnostic run passed (valid with diagDone) |
| diagResult | input | 16 | Diagnostic failure bits (valid with diagDone) |
| statusIn | input | 32 | Live status, 4 bytes |
| hizMode | input | 1 | Device is in hi-Z; unlocks restricted control bits |
| ctrlOut | output | 56 | Control register contents, 7 bytes |

## Verification
Every result is due one clock edge after its stimulus. Read data is valid from the edge that samples `regRdEn`, and the cleared fault state shows on the following read. A control write shows on `ctrlOut` from its own edge, and a diagnostic strobe changes what the next read returns. The bench drives inputs at falling edges and keeps a queue of expected read values. A monitor that saw `regRdEn` at the previous rising edge pops that queue and compares at the next falling edge. `ctrlOut` is compared at the falling edge right after each write.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int REG_W     = 8;
  localparam int ADDR_W    = 8;
  localparam int NUM_FAULT = 3;
  localparam int NUM_DIAG  = 2;
  localparam int NUM_STAT  = 4;
  localparam int NUM_CTRL  = 7;
  localparam int IDX_W     = $clog2(NUM_CTRL + 1);

  localparam logic [ADDR_W-1:0] DIAG_BASE = 8'h02;
  localparam logic [ADDR_W-1:0] STAT_BASE = 8'h04;

  localparam logic [ADDR_W-1:0] FAULT_ADDR [NUM_FAULT] = '{8'h00, 8'h01, 8'h13};
  localparam logic [ADDR_W-1:0] CTRL_ADDR  [NUM_CTRL]  =
    '{8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h10};

  typedef enum logic [2:0] {
    GRP_NONE,
    GRP_FAULT,
    GRP_DIAG,
    GRP_STAT,
    GRP_CTRL
  } regGroup_e;

  typedef struct packed {
    logic                 rdLoad;
    regGroup_e            rdGrp;
    logic [IDX_W-1:0]     rdIdx;
    logic [NUM_FAULT-1:0] faultRd;
    logic [NUM_CTRL-1:0]  ctrlWr;
  } regStrobes_t;
endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
(
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobes_t       stb
);
  regGroup_e        grp;
  logic [IDX_W-1:0] idx;

  // Address decode into register group and index within the group
  always_comb begin
    grp = GRP_NONE;
    idx = '0;
    for (int k = 0; k < NUM_FAULT; k++) begin
      if (regAddr == FAULT_ADDR[k]) begin
        grp = GRP_FAULT;
        idx = IDX_W'(k);
      end
    end
    if (regAddr >= DIAG_BASE && regAddr < DIAG_BASE + ADDR_W'(NUM_DIAG)) begin
      grp = GRP_DIAG;
      idx = IDX_W'(regAddr - DIAG_BASE);
    end
    if (regAddr >= STAT_BASE && regAddr < STAT_BASE + ADDR_W'(NUM_STAT)) begin
      grp = GRP_STAT;
      idx = IDX_W'(regAddr - STAT_BASE);
    end
    for (int c = 0; c < NUM_CTRL; c++) begin
      if (regAddr == CTRL_ADDR[c]) begin
        grp = GRP_CTRL;
        idx = IDX_W'(c);
      end
    end
  end

  always_comb begin
    stb.rdLoad  = regRdEn;
    stb.rdGrp   = grp;
    stb.rdIdx   = idx;
    stb.faultRd = '0;
    stb.ctrlWr  = '0;
    if (regRdEn && grp == GRP_FAULT) stb.faultRd = NUM_FAULT'(1) << idx;
    if (regWrEn && grp == GRP_CTRL)  stb.ctrlWr  = NUM_CTRL'(1) << idx;
  end
endmodule

// File: rtl/regbank_datapath.sv
module regbank_datapath
  import regbank_pkg::*;
#(
  parameter logic [NUM_CTRL*REG_W-1:0] CTRL_RESET    = '0,
  parameter logic [NUM_CTRL*REG_W-1:0] CTRL_HIZ_LOCK = '0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  regStrobes_t                stb,
  input  logic [REG_W-1:0]           regWrData,
  input  logic [NUM_FAULT*REG_W-1:0] faultIn,
  input  logic                       diagDone,
  input  logic                       diagPass,
  input  logic [NUM_DIAG*REG_W-1:0]  diagResult,
  input  logic [NUM_STAT*REG_W-1:0]  statusIn,
  input  logic                       hizMode,
  output logic [NUM_CTRL*REG_W-1:0]  ctrlOut,
  output logic [REG_W-1:0]           regRdData
);
  logic [NUM_FAULT*REG_W-1:0] faultQ;
  logic [NUM_FAULT*REG_W-1:0] faultClr;
  logic [NUM_DIAG*REG_W-1:0]  diagQ;
  logic [NUM_CTRL*REG_W-1:0]  ctrlQ;
  logic [REG_W-1:0]           rdMux;

  // Clear mask: only bits of the register being read whose condition is gone
  for (genvar k = 0; k < NUM_FAULT; k++) begin : gFaultClr
    assign faultClr[k*REG_W +: REG_W] =
      stb.faultRd[k] ? ~faultIn[k*REG_W +: REG_W] : '0;
  end

  // New faults are ORed in last so a same-cycle event always survives
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultQ <= '0;
    else       faultQ <= (faultQ & ~faultClr) | faultIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         diagQ <= '0;
    else if (diagDone) diagQ <= diagPass ? '0 : (diagQ | diagResult);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= CTRL_RESET;
    end else begin
      for (int c = 0; c < NUM_CTRL; c++) begin
        if (stb.ctrlWr[c]) begin
          if (hizMode) ctrlQ[c*REG_W +: REG_W] <= regWrData;
          else         ctrlQ[c*REG_W +: REG_W] <=
                         (ctrlQ[c*REG_W +: REG_W] & CTRL_HIZ_LOCK[c*REG_W +: REG_W]) |
                         (regWrData & ~CTRL_HIZ_LOCK[c*REG_W +: REG_W]);
        end
      end
    end
  end

  always_comb begin
    case (stb.rdGrp)
      GRP_FAULT: rdMux = REG_W'(faultQ   >> (stb.rdIdx * REG_W));
      GRP_DIAG:  rdMux = REG_W'(diagQ    >> (stb.rdIdx * REG_W));
      GRP_STAT:  rdMux = REG_W'(statusIn >> (stb.rdIdx * REG_W));
      GRP_CTRL:  rdMux = REG_W'(ctrlQ    >> (stb.rdIdx * REG_W));
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           regRdData <= '0;
    else if (stb.rdLoad) regRdData <= rdMux;
  end

  assign ctrlOut = ctrlQ;
endmodule

// File: rtl/fault_diag_regbank.sv
module fault_diag_regbank
  import regbank_pkg::*;
#(
  parameter logic [NUM_CTRL*REG_W-1:0] CTRL_RESET    = 56'h00_00_00_00_20_00_0F,
  parameter logic [NUM_CTRL*REG_W-1:0] CTRL_HIZ_LOCK = 56'h00_00_00_80_00_FF_00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regRdEn,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic [23:0] faultIn,
  input  logic        diagDone,
  input  logic        diagPass,
  input  logic [15:0] diagResult,
  input  logic [31:0] statusIn,
  input  logic        hizMode,
  output logic [55:0] ctrlOut
);
  regStrobes_t stb;

  regbank_ctrl uCtrl (
    .regRdEn (regRdEn),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .stb     (stb)
  );

  regbank_datapath #(
    .CTRL_RESET    (CTRL_RESET),
    .CTRL_HIZ_LOCK (CTRL_HIZ_LOCK)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .regWrData  (regWrData),
    .faultIn    (faultIn),
    .diagDone   (diagDone),
    .diagPass   (diagPass),
    .diagResult (diagResult),
    .statusIn   (statusIn),
    .hizMode    (hizMode),
    .ctrlOut    (ctrlOut),
    .regRdData  (regRdData)
  );
endmodule

// File: rtl/regbank_checker.sv
module regbank_checker #(
  parameter logic [55:0] LOCK = '0
) (
  input logic        clk,
  input logic        rstN,
  input logic        regRdEn,
  input logic        regWrEn,
  input logic [7:0]  regAddr,
  input logic [7:0]  regRdData,
  input logic [31:0] statusIn,
  input logic        hizMode,
  input logic [55:0] ctrlOut
);
  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  function automatic logic isMapped(input logic [7:0] a);
    return (a <= 8'h0D) || (a == 8'h10) || (a == 8'h13);
  endfunction

  AST_RDDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && !$past(regRdEn) |-> regRdData == $past(regRdData)); // R5

  AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr >= 8'h04 && regAddr <= 8'h07) |=>
      regRdData == 8'($past(statusIn) >> (8 * ($past(regAddr) - 8'h04)))); // R7

  AST_LOCKED_BITS: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && !$past(hizMode) |-> (ctrlOut & LOCK) == ($past(ctrlOut) & LOCK)); // R8

  AST_CTRL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && !$past(regWrEn) |-> ctrlOut == $past(ctrlOut)); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !isMapped(regAddr)) |=> regRdData == 8'h00); // R9
endmodule

bind fault_diag_regbank regbank_checker #(.LOCK(CTRL_HIZ_LOCK)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .regRdEn   (regRdEn),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regRdData (regRdData),
  .statusIn  (statusIn),
  .hizMode   (hizMode),
  .ctrlOut   (ctrlOut)
);

// File: tb/tb_fault_diag_regbank.sv
module tb_fault_diag_regbank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regRdEn = 1'b0, regWrEn = 1'b0;
  logic [7:0]  regAddr = '0, regWrData = '0;
  logic [7:0]  regRdData;
  logic [23:0] faultIn = '0;
  logic        diagDone = 1'b0, diagPass = 1'b0;
  logic [15:0] diagResult = '0;
  logic [31:0] statusIn = '0;
  logic        hizMode = 1'b0;
  logic [55:0] ctrlOut;

  int  testCount = 0;
  int  failCount = 0;
  bit  finished  = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       rdSeen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_diag_regbank dut (
    .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .faultIn(faultIn), .diagDone(diagDone), .diagPass(diagPass),
    .diagResult(diagResult), .statusIn(statusIn), .hizMode(hizMode),
    .ctrlOut(ctrlOut)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Driver: called at a falling edge, returns at the next falling edge
  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    regRdEn = 1'b1;
    regAddr = a;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    regWrEn   = 1'b1;
    regAddr   = a;
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Monitor: a read sampled at a rising edge is compared at the next falling edge
  always @(posedge clk) rdSeen <= regRdEn;
  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        check(64'(regRdData), 64'hx, "scoreboard underflow");
      end else begin
        logic [7:0] e;
        string      t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(64'(regRdData), 64'(e), t);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(64'(ctrlOut), 64'h00_00_00_00_20_00_0F, "R1 ctrl defaults");
    check(64'(regRdData), 64'h00, "R1 rdData reset");
    rd(8'h00, 8'h00, "R1 fault reg 0x00 after reset");
    rd(8'h0A, 8'h20, "R1 ctrl 0x0A default readback");

    // R2 latch and hold after input falls; R3 clearing read
    faultIn[3] = 1'b1;
    @(negedge clk);
    faultIn[3] = 1'b0;
    @(negedge clk);
    rd(8'h00, 8'h08, "R2 fault bit held after input fell");
    rd(8'h00, 8'h00, "R3 read with fault gone cleared bit");

    // R3 read while fault active keeps the bit
    faultIn[9] = 1'b1;
    @(negedge clk);
    rd(8'h01, 8'h02, "R2 fault reg 0x01 bit1");
    rd(8'h01, 8'h02, "R3 bit kept by read while active");
    faultIn[9] = 1'b0;
    rd(8'h01, 8'h02, "R3 read after fault fell returns bit");
    rd(8'h01, 8'h00, "R3 bit cleared by that read");

    // R4 new fault in clearing read cycle survives
    faultIn[16] = 1'b1;
    @(negedge clk);
    faultIn[16] = 1'b0;
    faultIn[17] = 1'b1;
    rd(8'h13, 8'h01, "R4 pre-read value of 0x13");
    faultIn[17] = 1'b0;
    rd(8'h13, 8'h02, "R4 same-cycle fault kept, old bit cleared");
    rd(8'h13, 8'h00, "R3 0x13 cleared");

    // R5 read data holds without reads
    repeat (3) @(negedge clk);
    check(64'(regRdData), 64'h00, "R5 rdData holds");

    // R6 diagnostics
    diagResult = 16'h0401; diagPass = 1'b0; diagDone = 1'b1;
    @(negedge clk);
    diagDone = 1'b0; diagResult = 16'hFFFF;
    rd(8'h02, 8'h01, "R6 diag 0x02 after failed run");
    rd(8'h03, 8'h04, "R6 diag 0x03 after failed run");
    rd(8'h02, 8'h01, "R6 diag not cleared by read");
    diagResult = 16'h0002; diagDone = 1'b1;
    @(negedge clk);
    diagDone = 1'b0;
    rd(8'h02, 8'h03, "R6 failed runs accumulate");
    diagResult = 16'hFFFF; diagPass = 1'b1; diagDone = 1'b1;
    @(negedge clk);
    diagDone = 1'b0; diagPass = 1'b0;
    rd(8'h02, 8'h00, "R6 pass clears 0x02");
    rd(8'h03, 8'h00, "R6 pass clears 0x03");

    // R7 live status
    statusIn = 32'hDEADBEEF;
    rd(8'h04, 8'hEF, "R7 status byte 0");
    rd(8'h07, 8'hDE, "R7 status byte 3");
    statusIn = 32'h12345678;
    rd(8'h05, 8'h56, "R7 status follows input");

    // R8 control writes and hi-Z lock
    hizMode = 1'b0;
    wr(8'h08, 8'h55);
    check(64'(ctrlOut[7:0]), 64'h55, "R8 unlocked write 0x08");
    wr(8'h09, 8'h33);
    check(64'(ctrlOut[15:8]), 64'h00, "R8 locked 0x09 ignored outside hi-Z");
    wr(8'h0B, 8'hFF);
    check(64'(ctrlOut[31:24]), 64'h7F, "R8 locked bit7 of 0x0B ignored");
    hizMode = 1'b1;
    wr(8'h09, 8'h33);
    check(64'(ctrlOut[15:8]), 64'h33, "R8 0x09 written in hi-Z");
    wr(8'h0B, 8'h80);
    check(64'(ctrlOut[31:24]), 64'h80, "R8 0x0B written in hi-Z");
    hizMode = 1'b0;
    wr(8'h10, 8'hC3);
    check(64'(ctrlOut[55:48]), 64'hC3, "R8 write 0x10 to byte 6");
    rd(8'h10, 8'hC3, "R8 readback 0x10");

    // R9 unmapped and read-only
    rd(8'h0E, 8'h00, "R9 unmapped 0x0E reads zero");
    rd(8'h55, 8'h00, "R9 unmapped 0x55 reads zero");
    wr(8'h20, 8'hFF);
    wr(8'h03, 8'hFF);
    check(64'(ctrlOut), 64'hC3_00_00_80_20_33_55, "R9 ctrl unchanged by other writes");
    wr(8'h00, 8'hFF);
    rd(8'h00, 8'h00, "R9 write to fault reg ignored");
    rd(8'h03, 8'h00, "R9 write to diag reg ignored");
    wr(8'h04, 8'hAA);
    rd(8'h04, 8'h78, "R9 write to status ignored");

    repeat (3) @(negedge clk);
    check(64'(expQ.size()), 64'd0, "R5 every read produced data");
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule